// File: doc/BRIEF.md
# BLDC Supervisory Mode Controller

This block is the supervisory state machine of a three-phase brushless motor drive. It sits between the operator's run/direction switch, the Hall position-change strobe, the status word that comes back from the half-bridge driver, and the serial command master. It decides on every cycle whether a frame is wanted, what kind of frame it is, and what switch pattern it carries. The serial transfer itself and the decoding of raw Hall edges belong to neighbouring blocks.

The machine has five states. `MS_IDLE` is the stopped mode. It keeps the driver in standby and asks for diagnostic poll frames without a break, so the driver status stays fresh. `MS_LAUNCH` sends the first commutation frame for the present rotor position and the chosen direction. `MS_DRIVE` is normal running, where a new commutation frame is asked for only when the rotor position changes. `MS_DERATE` is running with a thermal prewarning: the power-limit flag is raised and commutation goes on. `MS_TRIP` is the latched fault: all switches are forced off until the operator selects stop.

The transitions are as follows. IDLE→LAUNCH happens on a run request. LAUNCH→DRIVE happens on the acknowledge of the first frame. DRIVE→DERATE happens on a prewarning. LAUNCH, DRIVE or DERATE→TRIP happens on a hard fault. Any state→IDLE happens when the run request is released.

Top module: `bldc_mode_ctrl`

## Requirements
- R1: Reset enters the stopped mode. While stopped, `standby_en` is 1, `frame_req` is held at 1 with `frame_cmd` 0 (diagnostic poll), `frame_sw` is 0, `led` is 0 and `pwr_limit` is 0.
- R2: Status bit positions are fixed. In `status_word`, bit 0 is overload, bit 1 is overtemperature, bit 2 is undervoltage and bit 3 is thermal prewarning. The word is looked at only in a cycle where `status_valid` is 1. All other bits have no effect.
- R3: A run request while stopped moves to the launch state on the next edge. There, `standby_en` is 0 and `frame_req`=1 with `frame_cmd`=1. `frame_sw` is looked up from `hall_pos` (bits {C,B,A}) and `dir_ccw`, using the encoding bit0..2 = high side of phase A..C and bit3..5 = low side of phase A..C. For clockwise rotation the patterns are: 001→0x21, 010→0x0A, 011→0x22, 100→0x14, 101→0x11, 110→0x0C. Counter-clockwise swaps the high and low halves of the pattern. Hall codes 000 and 111 give 0. The request stays up until `frame_ack`, and then the block is running.
- R4: While running, a frame is requested only after `hall_evt`. The request rises on the next cycle with the pattern for the new position and stays up until `frame_ack`. If an event and an acknowledge fall in the same cycle, the request stays up with the newer pattern.
- R5: Releasing `run_req` returns the block to the stopped mode on the next edge from any state. This takes priority over faults, acknowledges and Hall events.
- R6: An overload, overtemperature or undervoltage bit during launch, running or degraded mode enters the fault state on the next edge. The fault state holds while `run_req` stays 1, whatever the later status words.
- R7: In the fault state, `frame_req`=1, `frame_cmd`=0, `frame_sw`=0 and `standby_en`=0, and Hall events do not change `frame_sw`.
- R8: A prewarning while running enters degraded mode. There, `pwr_limit`=1, `led`=1, and commutation frames continue on Hall events. Degraded mode is left only by stop or by a hard fault.
- R9: In normal running, `led` starts at 0 and toggles every `LED_DIV` cycles. It is steadily 1 in the degraded and fault states, and 0 when stopped.
- R10: The direction is sampled when the motor is started. Changes to `dir_ccw` have no effect on frames until the block has passed through the stopped mode.
- R11: Status words received while stopped latch no fault, so a later start proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_req | input | 1 | Operator switch in a run position |
| dir_ccw | input | 1 | Requested direction, 1 = counter-clockwise |
| hall_evt | input | 1 | One-cycle strobe on a rotor position change |
| hall_pos | input | 3 | Current Hall code {C,B,A} |
| frame_ack | input | 1 | Serial master has taken the requested frame |
| status_valid | input | 1 | Strobe: `status_word` holds a fresh driver reply |
| status_word | input | STAT_W | Driver status word |
| frame_req | output | 1 | A frame is wanted |
| frame_cmd | output | 1 | 1 = commutation frame, 0 = diagnostic poll |
| frame_sw | output | 6 | Switch pattern carried in the frame |
| standby_en | output | 1 | Put the driver into standby |
| pwr_limit | output | 1 | Reduce output power |
| led | output | 1 | Indicator lamp |

## Verification
Two functions can fall in the same cycle. The first collision is a Hall event arriving in the very cycle that the serial master acknowledges the previous frame. The bench drives `hall_evt` and `frame_ack` high together and expects the request to stay up and carry the new position's pattern, not to drop. The second collision is a stop falling in the same cycle as a Hall event. Here the bench expects standby with a cleared pattern on the next cycle, with the stop winning over the new commutation.

// File: rtl/bldc_mode_pkg.sv
package bldc_mode_pkg;

    typedef enum logic [2:0] {
        MS_IDLE   = 3'd0,
        MS_LAUNCH = 3'd1,
        MS_DRIVE  = 3'd2,
        MS_DERATE = 3'd3,
        MS_TRIP   = 3'd4
    } mode_e;

    localparam int SW_W = 6;

endpackage

// File: rtl/bldc_status_dec.sv
module bldc_status_dec #(
    parameter int STAT_W  = 16,
    parameter int OVL_BIT = 0,
    parameter int OVT_BIT = 1,
    parameter int UV_BIT  = 2,
    parameter int PRE_BIT = 3
) (
    input  logic              valid,
    input  logic [STAT_W-1:0] word,
    output logic              hard_flt,
    output logic              warn_flt
);
    always_comb begin
        hard_flt = valid && (word[OVL_BIT] || word[OVT_BIT] || word[UV_BIT]);
        warn_flt = valid && word[PRE_BIT];
    end
endmodule

// File: rtl/bldc_commut_lut.sv
module bldc_commut_lut
    import bldc_mode_pkg::*;
(
    input  logic            ccw,
    input  logic [2:0]      hall,
    output logic [SW_W-1:0] sw
);
    localparam int HALF = SW_W / 2;

    logic [SW_W-1:0] cw_pat;

    always_comb begin
        unique case (hall)
            3'b001:  cw_pat = 6'h21;
            3'b010:  cw_pat = 6'h0A;
            3'b011:  cw_pat = 6'h22;
            3'b100:  cw_pat = 6'h14;
            3'b101:  cw_pat = 6'h11;
            3'b110:  cw_pat = 6'h0C;
            default: cw_pat = '0;
        endcase
        sw = ccw ? {cw_pat[HALF-1:0], cw_pat[SW_W-1:HALF]} : cw_pat;
    end
endmodule

// File: rtl/bldc_led_blink.sv
module bldc_led_blink #(
    parameter int LED_DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic blink
);
    localparam int CNT_W = (LED_DIV > 1) ? $clog2(LED_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LED_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            blink <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            blink <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            blink <= ~blink;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bldc_mode_ctrl.sv
module bldc_mode_ctrl
    import bldc_mode_pkg::*;
#(
    parameter int STAT_W  = 16,
    parameter int LED_DIV = 50000,
    parameter int OVL_BIT = 0,
    parameter int OVT_BIT = 1,
    parameter int UV_BIT  = 2,
    parameter int PRE_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic              dir_ccw,
    input  logic              hall_evt,
    input  logic [2:0]        hall_pos,
    input  logic              frame_ack,
    input  logic              status_valid,
    input  logic [STAT_W-1:0] status_word,
    output logic              frame_req,
    output logic              frame_cmd,
    output logic [5:0]        frame_sw,
    output logic              standby_en,
    output logic              pwr_limit,
    output logic              led
);
    mode_e           st_q, st_d;
    logic            dir_q;
    logic            pend_q, pend_d;
    logic [SW_W-1:0] sw_q, sw_d;
    logic [SW_W-1:0] lut_sw;
    logic            dir_sel;
    logic            hard_flt, warn_flt;
    logic            blink;

    bldc_status_dec #(
        .STAT_W (STAT_W),
        .OVL_BIT(OVL_BIT),
        .OVT_BIT(OVT_BIT),
        .UV_BIT (UV_BIT),
        .PRE_BIT(PRE_BIT)
    ) u_stat (
        .valid   (status_valid),
        .word    (status_word),
        .hard_flt(hard_flt),
        .warn_flt(warn_flt)
    );

    assign dir_sel = (st_q == MS_IDLE) ? dir_ccw : dir_q;

    bldc_commut_lut u_lut (
        .ccw (dir_sel),
        .hall(hall_pos),
        .sw  (lut_sw)
    );

    bldc_led_blink #(
        .LED_DIV(LED_DIV)
    ) u_blink (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st_q == MS_DRIVE),
        .blink(blink)
    );

    // next state, pending request and pattern
    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        sw_d   = sw_q;
        unique case (st_q)
            MS_IDLE: begin
                if (run_req) begin
                    st_d = MS_LAUNCH;
                    sw_d = lut_sw;
                end
            end
            MS_LAUNCH: begin
                if (!run_req) begin
                    st_d = MS_IDLE;
                end else if (hard_flt) begin
                    st_d = MS_TRIP;
                end else begin
                    if (hall_evt) sw_d = lut_sw;
                    if (frame_ack) begin
                        st_d   = MS_DRIVE;
                        pend_d = hall_evt;
                    end
                end
            end
            MS_DRIVE, MS_DERATE: begin
                if (!run_req) begin
                    st_d = MS_IDLE;
                end else if (hard_flt) begin
                    st_d = MS_TRIP;
                end else begin
                    if (st_q == MS_DRIVE && warn_flt) st_d = MS_DERATE;
                    if (hall_evt) begin
                        pend_d = 1'b1;
                        sw_d   = lut_sw;
                    end else if (frame_ack) begin
                        pend_d = 1'b0;
                    end
                end
            end
            MS_TRIP: begin
                if (!run_req) st_d = MS_IDLE;
            end
            default: st_d = MS_IDLE;
        endcase
        if (st_d == MS_IDLE || st_d == MS_TRIP) begin
            pend_d = 1'b0;
            sw_d   = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= MS_IDLE;
            pend_q <= 1'b0;
            sw_q   <= '0;
            dir_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
            sw_q   <= sw_d;
            if (st_q == MS_IDLE && run_req) dir_q <= dir_ccw;
        end
    end

    // outputs
    always_comb begin
        frame_req  = 1'b0;
        frame_cmd  = 1'b0;
        standby_en = 1'b0;
        pwr_limit  = 1'b0;
        led        = 1'b0;
        unique case (st_q)
            MS_IDLE: begin
                standby_en = 1'b1;
                frame_req  = 1'b1;
            end
            MS_LAUNCH: begin
                frame_req = 1'b1;
                frame_cmd = 1'b1;
            end
            MS_DRIVE: begin
                frame_req = pend_q;
                frame_cmd = 1'b1;
                led       = blink;
            end
            MS_DERATE: begin
                frame_req = pend_q;
                frame_cmd = 1'b1;
                pwr_limit = 1'b1;
                led       = 1'b1;
            end
            MS_TRIP: begin
                frame_req = 1'b1;
                led       = 1'b1;
            end
            default: ;
        endcase
        frame_sw = sw_q;
    end
endmodule

// File: rtl/bldc_mode_ctrl_chk.sv
module bldc_mode_ctrl_chk
    import bldc_mode_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       run_req,
    input logic       dir_ccw,
    input logic       hall_evt,
    input logic       frame_ack,
    input logic       status_valid,
    input logic       frame_req,
    input logic       frame_cmd,
    input logic [5:0] frame_sw,
    input logic       standby_en,
    input logic       pwr_limit,
    input logic       led,
    input mode_e      st_q,
    input logic       dir_q
);
    assert_launch_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_en && run_req) |=> (frame_req && frame_cmd && !standby_en));

    assert_stop_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_req |=> (standby_en && frame_sw == 6'd0));

    assert_trip_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MS_TRIP) |-> (frame_sw == 6'd0 && !frame_cmd && frame_req));

    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MS_DRIVE && !frame_req && !hall_evt && run_req && !status_valid)
            |=> !frame_req);

    assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == MS_DRIVE || st_q == MS_DERATE) && frame_req && !frame_ack
            && run_req && !status_valid) |=> frame_req);

    assert_dir_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby_en && $past(!standby_en)) |-> $stable(dir_q));

    assert_derate_lamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_limit |-> (led && !standby_en));

    assert_trip_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MS_TRIP && run_req) |=> (st_q == MS_TRIP));
endmodule

bind bldc_mode_ctrl bldc_mode_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_req     (run_req),
    .dir_ccw     (dir_ccw),
    .hall_evt    (hall_evt),
    .frame_ack   (frame_ack),
    .status_valid(status_valid),
    .frame_req   (frame_req),
    .frame_cmd   (frame_cmd),
    .frame_sw    (frame_sw),
    .standby_en  (standby_en),
    .pwr_limit   (pwr_limit),
    .led         (led),
    .st_q        (st_q),
    .dir_q       (dir_q)
);

// File: tb/bldc_mode_ctrl_test.sv
module bldc_mode_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LED_DIV    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_req = 1'b0;
    logic        dir_ccw = 1'b0;
    logic        hall_evt = 1'b0;
    logic [2:0]  hall_pos = 3'b000;
    logic        frame_ack = 1'b0;
    logic        status_valid = 1'b0;
    logic [15:0] status_word = 16'h0000;
    logic        frame_req, frame_cmd, standby_en, pwr_limit, led;
    logic [5:0]  frame_sw;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // {dir_ccw, hall_pos, expected pattern}
    localparam logic [9:0] VEC [14] = '{
        {1'b0, 3'b001, 6'h21}, {1'b0, 3'b010, 6'h0A}, {1'b0, 3'b011, 6'h22},
        {1'b0, 3'b100, 6'h14}, {1'b0, 3'b101, 6'h11}, {1'b0, 3'b110, 6'h0C},
        {1'b0, 3'b000, 6'h00},
        {1'b1, 3'b001, 6'h0C}, {1'b1, 3'b010, 6'h11}, {1'b1, 3'b011, 6'h14},
        {1'b1, 3'b100, 6'h22}, {1'b1, 3'b101, 6'h0A}, {1'b1, 3'b110, 6'h21},
        {1'b1, 3'b111, 6'h00}
    };

    bldc_mode_ctrl #(.STAT_W(16), .LED_DIV(LED_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .dir_ccw(dir_ccw),
        .hall_evt(hall_evt), .hall_pos(hall_pos), .frame_ack(frame_ack),
        .status_valid(status_valid), .status_word(status_word),
        .frame_req(frame_req), .frame_cmd(frame_cmd), .frame_sw(frame_sw),
        .standby_en(standby_en), .pwr_limit(pwr_limit), .led(led)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic start_run(input logic d, input logic [2:0] h);
        run_req = 1'b0; tick(); tick();
        dir_ccw = d; hall_pos = h; run_req = 1'b1; tick();
        frame_ack = 1'b1; tick(); frame_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 standby", standby_en, 1);
        chk("R1 poll req", {frame_req, frame_cmd}, 2'b10);
        chk("R1 sw", frame_sw, 0);
        chk("R1 led/pwr", {led, pwr_limit}, 0);

        // R3 table walk
        for (int i = 0; i < 14; i++) begin
            run_req = 1'b0; tick(); tick();
            dir_ccw = VEC[i][9]; hall_pos = VEC[i][8:6]; run_req = 1'b1;
            tick();
            chk("R3 launch req/cmd/standby", {frame_req, frame_cmd, standby_en}, 3'b110);
            chk("R3 launch pattern", frame_sw, {26'd0, VEC[i][5:0]});
        end

        // R11 status while stopped ignored
        run_req = 1'b0; tick(); tick();
        status_valid = 1'b1; status_word = 16'h0007; tick();
        status_valid = 1'b0; status_word = 16'h0000;
        chk("R11 still stopped", {standby_en, led}, 2'b10);
        dir_ccw = 1'b0; hall_pos = 3'b101; run_req = 1'b1; tick();
        chk("R11 start normal", frame_sw, 6'h11);
        frame_ack = 1'b1; tick(); frame_ack = 1'b0;
        // now running, LED counter at 0
        chk("R4 no frame after ack", frame_req, 0);
        chk("R9 led starts off", led, 0);
        tick(); tick(); tick();
        chk("R4 idle without hall", frame_req, 0);
        tick();
        chk("R9 led toggles", led, 1);

        // R10 direction change ignored
        dir_ccw = 1'b1; hall_pos = 3'b001; hall_evt = 1'b1; tick(); hall_evt = 1'b0;
        chk("R10 cw kept", frame_sw, 6'h21);
        chk("R4 req on hall", frame_req, 1);
        // R4 hall and ack same cycle
        hall_pos = 3'b011; hall_evt = 1'b1; frame_ack = 1'b1; tick();
        hall_evt = 1'b0; frame_ack = 1'b0;
        chk("R4 collide req held", frame_req, 1);
        chk("R4 collide new pattern", frame_sw, 6'h22);
        frame_ack = 1'b1; tick(); frame_ack = 1'b0;
        chk("R4 ack drops req", frame_req, 0);

        // R2 unrelated status bits ignored
        status_valid = 1'b1; status_word = 16'hFFF0; tick();
        status_valid = 1'b0; status_word = 16'h0000;
        chk("R2 upper bits ignored", {pwr_limit, standby_en}, 0);
        hall_pos = 3'b100; hall_evt = 1'b1; tick(); hall_evt = 1'b0;
        chk("R2 still commutating", frame_sw, 6'h14);
        frame_ack = 1'b1; tick(); frame_ack = 1'b0;

        // R8 prewarning
        status_valid = 1'b1; status_word = 16'h0008; tick();
        status_valid = 1'b0; status_word = 16'h0000;
        chk("R8 derate flags", {pwr_limit, led, standby_en}, 3'b110);
        hall_pos = 3'b010; hall_evt = 1'b1; tick(); hall_evt = 1'b0;
        chk("R8 commutation continues", {frame_req, frame_sw}, {1'b1, 6'h0A});
        frame_ack = 1'b1; tick(); frame_ack = 1'b0;
        tick(); tick();
        chk("R8 stays derated", pwr_limit, 1);

        // R6/R7 overload from derate
        status_valid = 1'b1; status_word = 16'h0001; tick();
        status_valid = 1'b0; status_word = 16'h0000;
        chk("R7 trip frame", {frame_req, frame_cmd, frame_sw}, {1'b1, 1'b0, 6'h00});
        chk("R7 trip flags", {standby_en, pwr_limit, led}, 3'b001);
        status_valid = 1'b1; hall_pos = 3'b110; hall_evt = 1'b1; tick();
        status_valid = 1'b0; hall_evt = 1'b0;
        tick();
        chk("R6 latched", {led, frame_sw, standby_en}, {1'b1, 6'h00, 1'b0});
        run_req = 1'b0; tick();
        chk("R6 clear on stop", {standby_en, led}, 2'b10);

        // R5 stop collides with hall event
        start_run(1'b1, 3'b110);
        chk("R3 ccw run", frame_sw, 6'h21);
        run_req = 1'b0; hall_pos = 3'b010; hall_evt = 1'b1; tick(); hall_evt = 1'b0;
        chk("R5 stop wins", {standby_en, frame_cmd, frame_sw}, {1'b1, 1'b0, 6'h00});

        // R6 undervoltage during launch
        dir_ccw = 1'b0; hall_pos = 3'b100; run_req = 1'b1; tick();
        status_valid = 1'b1; status_word = 16'h0004; tick();
        status_valid = 1'b0; status_word = 16'h0000;
        chk("R6 launch trip", {led, frame_sw, standby_en}, {1'b1, 6'h00, 1'b0});

        // R6 overtemperature while running
        start_run(1'b0, 3'b011);
        status_valid = 1'b1; status_word = 16'h0002; tick();
        status_valid = 1'b0; status_word = 16'h0000;
        chk("R6 overtemp trip", {led, frame_cmd, frame_sw}, {1'b1, 1'b0, 6'h00});

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule